// File: doc/BRIEF.md
# Single-Clock FIFO with Mark and Rewind

This block is a synchronous first-in first-out buffer on one clock, moving one word per edge in each direction. Besides ordinary buffering, it can pin a word that has already left through the output register and later rewind the read side to that word. The data from the pin onward can then be replayed as many times as needed. While a pin is held, the write side keeps accepting data, but it is never allowed to reach the pinned slot. This keeps the replay data intact.

A strap input, sampled while master reset is low, selects one of two read disciplines. In standard mode, every word, including the first, is pulled into `rd_data` by `rd_en`. The flags are `empty_n` (unread words exist) and `full_n` (space exists). In fall-through mode, the read port is a valid/ready stream: `out_valid` rises when a word sits in `rd_data`, and `rd_en` acts as the consumer's ready. A word leaves on any edge where both are high, and the next word is loaded on that same edge when one exists. On the write side, `in_ready` gives back-pressure: a word moves when `wr_en` and `in_ready` are both high. The flags of the mode that is not selected are held low. Both resets act synchronously on the rising clock edge.

Top module: `rtm_fifo`

## Requirements
- R1: With `mrst_n` low on an edge, the mode is latched from `fall_strap` (0 = standard, 1 = fall-through), both pointers are cleared and `rd_data` becomes 0. In standard mode the flags then read `empty_n`=0 and `full_n`=1. In fall-through mode they read `out_valid`=0 and `in_ready`=1. The two flags of the unused mode are 0.
- R2: With `prst_n` low on an edge, the pointers, `rd_data` and the pin state are cleared and the flags show an empty FIFO, but the mode latched at the last master reset is kept. Words written before the partial reset are not read afterwards.
- R3: In standard mode, an edge with `rd_en` high and `empty_n` high loads the oldest unread word into `rd_data`. `empty_n` is high exactly when unread words exist and no rewind setup is in progress.
- R4: In fall-through mode, a word written into an empty FIFO appears on `rd_data` with `out_valid` high on the edge after the write edge, without `rd_en`. Each edge with `rd_en` and `out_valid` both high replaces it with the next word, or drops `out_valid` if none is left.
- R5: A read request is ignored while the FIFO is empty: `rd_data` holds. A write request is ignored while `full_n`/`in_ready` is low. Without a pin, the buffer becomes full at 2^AW words.
- R6: An edge with `mark_hold` high pins the word now in `rd_data` and enters pin mode, provided no pin is active, a word is valid (standard: `empty_n` high and at least one word has been read since reset; fall-through: `out_valid` high), and at most 2^AW-2 words will be unread after the edge. Pin mode lasts while `mark_hold` stays high. An edge with `mark_hold` low leaves it, and a later rise pins anew.
- R7: In pin mode, the span from the pinned word through the newest written word never exceeds 2^AW-1. `full_n`/`in_ready` drop when that span is reached and rise again once pin mode ends.
- R8: A rewind is accepted on an edge where `rewind_n` is low, pin mode is active with `mark_hold` still high, `rd_en` is low, no setup is in progress, and the span from the pin to the write pointer is at least MIN_GAP words. The read pointer is then moved to the pinned word.
- R9: In standard mode, `empty_n` is low for the one cycle after the accepting edge and high again after the next edge. The following reads return the pinned word first, then its successors.
- R10: In fall-through mode, `out_valid` is low for the one cycle after the accepting edge. On the next edge, the pinned word is loaded with `out_valid` high and no `rd_en`. Later words need `rd_en`.
- R11: A rewind request outside pin mode, or with a span shorter than MIN_GAP, is ignored: the flags stay as they were and reading continues from where it was.
- R12: A rewind may be repeated any number of times, and each one restarts at the same pinned word.
- R13: Writes continue during pin mode, and a write on the same edge as an accepted rewind is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| mrst_n | input | 1 | Master reset, active low, synchronous; latches the mode |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps the mode |
| fall_strap | input | 1 | Mode strap, sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request / producer valid |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read request / consumer ready |
| mark_hold | input | 1 | Pins the current output word and holds pin mode while high |
| rewind_n | input | 1 | Rewind request, active low |
| rd_data | output | DW | Output register |
| empty_n | output | 1 | Standard mode: unread words exist |
| full_n | output | 1 | Standard mode: space exists |
| out_valid | output | 1 | Fall-through mode: `rd_data` holds a valid word |
| in_ready | output | 1 | Fall-through mode: space exists |

## Verification
Two functions can act on the same edge: a write, and an accepted rewind or the pin limit it is measured against. The bench keeps `wr_en` high on the very edge where `rewind_n` is low. It then fills the buffer while the pin is held and counts how many writes are taken before `full_n` drops. The count is exact only if the write on the rewind edge was stored and the limit sits one slot short of the pinned word. The bench also offers a rewind in the same cycle as an empty read, and a pin just before the buffer turns full, and checks that each edge keeps its own effect.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FALL = 1'b1
  } mode_e;
endpackage

// File: rtl/rtm_store.sv
module rtm_store #(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rtm_wr_side.sv
module rtm_wr_side #(
  parameter int AW = 7
) (
  input  logic        clk,
  input  logic        clr_n,
  input  logic        wr_en,
  input  logic        rt_mode,
  input  logic [AW:0] mark_ptr,
  input  logic [AW:0] rptr,
  output logic [AW:0] wptr,
  output logic [AW:0] level,
  output logic [AW:0] span,
  output logic        wr_block,
  output logic        wr_fire
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] PIN_LIM  = PW'(DEPTH - 1);

  assign level    = wptr - rptr;
  assign span     = wptr - mark_ptr;
  assign wr_block = (level == FULL_LVL) || (rt_mode && (span >= PIN_LIM));
  assign wr_fire  = clr_n && wr_en && !wr_block;

  always_ff @(posedge clk) begin
    if (!clr_n)       wptr <= '0;
    else if (wr_fire) wptr <= wptr + PW'(1);
  end
endmodule

// File: rtl/rtm_rd_side.sv
module rtm_rd_side #(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          fall,
  input  logic          rd_en,
  input  logic [AW:0]   level,
  input  logic          rt_busy,
  input  logic          rewind_go,
  input  logic [AW:0]   mark_ptr,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW:0]   rptr,
  output logic [DW-1:0] q,
  output logic          q_valid,
  output logic          q_has
);
  localparam int PW = AW + 1;

  logic have_word;
  logic std_load;
  logic fall_load;
  logic load;

  assign have_word = (level != '0);
  assign std_load  = !fall && rd_en && have_word && !rt_busy;
  assign fall_load = fall && (!q_valid || rd_en) && have_word;
  assign load      = !rewind_go && (std_load || fall_load);

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      rptr    <= '0;
      q       <= '0;
      q_valid <= 1'b0;
      q_has   <= 1'b0;
    end else if (rewind_go) begin
      rptr <= mark_ptr;
      if (fall) q_valid <= 1'b0;
    end else if (load) begin
      q       <= mem_rdata;
      rptr    <= rptr + PW'(1);
      q_has   <= 1'b1;
      q_valid <= fall;
    end else if (fall && rd_en && q_valid) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rtm_mark_ctl.sv
module rtm_mark_ctl #(
  parameter int AW      = 7,
  parameter int MIN_GAP = 64
) (
  input  logic        clk,
  input  logic        clr_n,
  input  logic        fall,
  input  logic        mark_hold,
  input  logic        rewind_n,
  input  logic        rd_en,
  input  logic [AW:0] rptr,
  input  logic [AW:0] level,
  input  logic [AW:0] span,
  input  logic        wr_fire,
  input  logic        q_has,
  input  logic        q_valid,
  output logic        rt_mode,
  output logic        rt_busy,
  output logic [AW:0] mark_ptr,
  output logic        mark_go,
  output logic        rewind_go
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW:0]   ROOM_LIM = (PW+1)'(DEPTH - 2);
  localparam logic [PW-1:0] GAP_LIM  = PW'(MIN_GAP);

  logic        data_ok;
  logic        room_ok;
  logic [PW:0] level_next;

  assign data_ok    = fall ? q_valid : (q_has && (level != '0) && !rt_busy);
  assign level_next = {1'b0, level} + {{PW{1'b0}}, wr_fire};
  assign room_ok    = (level_next <= ROOM_LIM);
  assign mark_go    = clr_n && mark_hold && !rt_mode && data_ok && room_ok;
  assign rewind_go  = clr_n && !rewind_n && mark_hold && rt_mode && !rd_en &&
                      !rt_busy && (span >= GAP_LIM);

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      rt_mode  <= 1'b0;
      rt_busy  <= 1'b0;
      mark_ptr <= '0;
    end else begin
      rt_mode <= mark_hold && (rt_mode || mark_go);
      rt_busy <= rewind_go;
      if (mark_go) mark_ptr <= rptr - PW'(1);
    end
  end
endmodule

// File: rtl/rtm_fifo.sv
module rtm_fifo
  import rtm_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 7,
  parameter int MIN_GAP = 64
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fall_strap,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          mark_hold,
  input  logic          rewind_n,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          full_n,
  output logic          out_valid,
  output logic          in_ready
);
  localparam int PW = AW + 1;

  mode_e         mode_q;
  logic          fall;
  logic          clr_n;
  logic [PW-1:0] wptr, rptr, mark_ptr, level, span;
  logic          wr_block, wr_fire;
  logic          rt_mode, rt_busy, mark_go, rewind_go;
  logic          q_valid, q_has;
  logic [DW-1:0] mem_rdata;

  assign clr_n = mrst_n & prst_n;

  always_ff @(posedge clk) begin
    if (!mrst_n) mode_q <= fall_strap ? MODE_FALL : MODE_STD;
  end

  assign fall = (mode_q == MODE_FALL);

  rtm_store #(.DW(DW), .AW(AW)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wptr[AW-1:0]),
    .wdata (wr_data),
    .raddr (rptr[AW-1:0]),
    .rdata (mem_rdata)
  );

  rtm_wr_side #(.AW(AW)) u_wr (
    .clk      (clk),
    .clr_n    (clr_n),
    .wr_en    (wr_en),
    .rt_mode  (rt_mode),
    .mark_ptr (mark_ptr),
    .rptr     (rptr),
    .wptr     (wptr),
    .level    (level),
    .span     (span),
    .wr_block (wr_block),
    .wr_fire  (wr_fire)
  );

  rtm_rd_side #(.DW(DW), .AW(AW)) u_rd (
    .clk       (clk),
    .clr_n     (clr_n),
    .fall      (fall),
    .rd_en     (rd_en),
    .level     (level),
    .rt_busy   (rt_busy),
    .rewind_go (rewind_go),
    .mark_ptr  (mark_ptr),
    .mem_rdata (mem_rdata),
    .rptr      (rptr),
    .q         (rd_data),
    .q_valid   (q_valid),
    .q_has     (q_has)
  );

  rtm_mark_ctl #(.AW(AW), .MIN_GAP(MIN_GAP)) u_mark (
    .clk       (clk),
    .clr_n     (clr_n),
    .fall      (fall),
    .mark_hold (mark_hold),
    .rewind_n  (rewind_n),
    .rd_en     (rd_en),
    .rptr      (rptr),
    .level     (level),
    .span      (span),
    .wr_fire   (wr_fire),
    .q_has     (q_has),
    .q_valid   (q_valid),
    .rt_mode   (rt_mode),
    .rt_busy   (rt_busy),
    .mark_ptr  (mark_ptr),
    .mark_go   (mark_go),
    .rewind_go (rewind_go)
  );

  assign empty_n   = !fall && (level != '0) && !rt_busy;
  assign full_n    = !fall && !wr_block;
  assign out_valid = fall && q_valid;
  assign in_ready  = fall && !wr_block;
endmodule

// File: rtl/rtm_fifo_chk.sv
module rtm_fifo_chk #(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          mrst_n,
  input logic          prst_n,
  input logic          fall,
  input logic [AW:0]   wptr,
  input logic [AW:0]   rptr,
  input logic [AW:0]   mark_ptr,
  input logic          rt_mode,
  input logic          rewind_go,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          empty_n,
  input logic          full_n,
  input logic          out_valid,
  input logic          in_ready
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          live;
  logic [PW-1:0] pin_span;
  logic [PW-1:0] fill;

  assign live     = mrst_n && prst_n;
  assign pin_span = wptr - mark_ptr;
  assign fill     = wptr - rptr;

  // R7
  pin_span_chk: assert property (@(posedge clk) disable iff (!live)
    rt_mode |-> (pin_span <= PW'(DEPTH - 1)));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!live)
    fill <= PW'(DEPTH));

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!live)
    ((!fall && !full_n) || (fall && !in_ready)) |=> $stable(wptr));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!live)
    (!fall && !empty_n && rd_en) |=> $stable(rd_data));

  // R8
  rewind_ptr_chk: assert property (@(posedge clk) disable iff (!live)
    rewind_go |=> (rptr == $past(mark_ptr)));

  // R9
  std_setup_chk: assert property (@(posedge clk) disable iff (!live)
    (!fall && rewind_go) |=> !empty_n);

  // R10
  fall_drop_chk: assert property (@(posedge clk) disable iff (!live)
    (fall && rewind_go) |=> !out_valid);

  // R10
  fall_back_chk: assert property (@(posedge clk) disable iff (!live)
    (fall && $past(rewind_go, 2) && $past(live)) |-> out_valid);
endmodule

bind rtm_fifo rtm_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .mrst_n    (mrst_n),
  .prst_n    (prst_n),
  .fall      (fall),
  .wptr      (wptr),
  .rptr      (rptr),
  .mark_ptr  (mark_ptr),
  .rt_mode   (rt_mode),
  .rewind_go (rewind_go),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .empty_n   (empty_n),
  .full_n    (full_n),
  .out_valid (out_valid),
  .in_ready  (in_ready)
);

// File: tb/rtm_fifo_tb.sv
module rtm_fifo_tb;
  localparam int DW = 16;
  localparam int AW = 7;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic mrst_n, prst_n, fall_strap, wr_en, rd_en, mark_hold, rewind_n;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic empty_n, full_n, out_valid, in_ready;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rtm_fifo #(.DW(DW), .AW(AW), .MIN_GAP(64)) u_dut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fall_strap(fall_strap),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .mark_hold(mark_hold),
    .rewind_n(rewind_n), .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n),
    .out_valid(out_valid), .in_ready(in_ready)
  );

  // {wr, rd, din[15:0], expected empty_n, expected rd_data[15:0]}, standard mode
  localparam logic [34:0] VEC [8] = '{
    {1'b1, 1'b0, 16'h0011, 1'b1, 16'h0000},
    {1'b1, 1'b0, 16'h0022, 1'b1, 16'h0000},
    {1'b0, 1'b1, 16'h0000, 1'b1, 16'h0011},
    {1'b1, 1'b1, 16'h0033, 1'b1, 16'h0022},
    {1'b0, 1'b1, 16'h0000, 1'b0, 16'h0033},
    {1'b0, 1'b1, 16'h0000, 1'b0, 16'h0033},
    {1'b1, 1'b0, 16'h0044, 1'b1, 16'h0033},
    {1'b0, 1'b1, 16'h0000, 1'b0, 16'h0044}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; rd_en = 1'b0; rewind_n = 1'b1;
  endtask

  task automatic put(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d; rd_en = 1'b0;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic take();
    rd_en = 1'b1; wr_en = 1'b0;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic part_reset();
    idle(); prst_n = 1'b0;
    tick();
    prst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    mrst_n = 1'b0; prst_n = 1'b1; fall_strap = 1'b0; mark_hold = 1'b0;
    wr_data = '0; idle();
    tick(); tick();
    mrst_n = 1'b1;
    // R1 standard reset state
    chk("R1 empty_n", 32'(empty_n), 32'h0);
    chk("R1 full_n", 32'(full_n), 32'h1);
    chk("R1 out_valid", 32'(out_valid), 32'h0);
    chk("R1 in_ready", 32'(in_ready), 32'h0);
    chk("R1 rd_data", 32'(rd_data), 32'h0);

    // R3 / R5 table-driven standard traffic
    for (int i = 0; i < 8; i++) begin
      wr_en = VEC[i][34]; rd_en = VEC[i][33]; wr_data = VEC[i][32:17];
      tick();
      chk($sformatf("R3 vec%0d empty_n", i), 32'(empty_n), 32'(VEC[i][16]));
      chk($sformatf("R3 vec%0d rd_data", i), 32'(rd_data), 32'(VEC[i][15:0]));
      chk($sformatf("R5 vec%0d full_n", i), 32'(full_n), 32'h1);
    end
    idle();

    // R5 fill to capacity, extra write ignored
    for (int i = 0; i < DEPTH; i++) put(16'h0100 + 16'(i));
    chk("R5 full at capacity", 32'(full_n), 32'h0);
    put(16'hDEAD);
    chk("R5 still full", 32'(full_n), 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      take();
      chk("R5 drain order", 32'(rd_data), 32'(16'h0100 + 16'(i)));
    end
    chk("R5 empty after drain", 32'(empty_n), 32'h0);
    take();
    chk("R5 read on empty ignored", 32'(rd_data), 32'h017F);

    // R2 partial reset
    put(16'h0A01); put(16'h0A02); put(16'h0A03);
    part_reset();
    chk("R2 empty_n", 32'(empty_n), 32'h0);
    chk("R2 full_n", 32'(full_n), 32'h1);
    chk("R2 rd_data", 32'(rd_data), 32'h0);
    chk("R2 mode kept", 32'(out_valid | in_ready), 32'h0);
    put(16'h0055); take();
    chk("R2 old words gone", 32'(rd_data), 32'h0055);

    // Standard pin and rewind
    part_reset();
    for (int i = 0; i < 70; i++) put(16'h0200 + 16'(i));
    for (int i = 0; i < 5; i++) take();
    chk("R3 fifth word", 32'(rd_data), 32'h0204);
    rewind_n = 1'b0; tick(); rewind_n = 1'b1;
    chk("R11 no pin, flag kept", 32'(empty_n), 32'h1);
    take();
    chk("R11 no pin, pointer kept", 32'(rd_data), 32'h0205);
    mark_hold = 1'b1; tick();
    take(); take(); take();
    chk("R6 reads continue in pin mode", 32'(rd_data), 32'h0208);
    rewind_n = 1'b0; tick(); rewind_n = 1'b1;
    chk("R9 setup drops empty_n", 32'(empty_n), 32'h0);
    tick();
    chk("R9 setup done", 32'(empty_n), 32'h1);
    take();
    chk("R9 pinned word first", 32'(rd_data), 32'h0205);
    take(); take();
    chk("R9 successor", 32'(rd_data), 32'h0207);
    // R13 write on the rewind edge
    rewind_n = 1'b0; wr_en = 1'b1; wr_data = 16'h03AA; tick();
    rewind_n = 1'b1; wr_en = 1'b0;
    chk("R12 second setup", 32'(empty_n), 32'h0);
    tick();
    take();
    chk("R12 second rewind to pin", 32'(rd_data), 32'h0205);
    begin
      int n = 0;
      for (int i = 0; i < 100; i++) begin
        if (full_n) begin put(16'h0600 + 16'(i)); n++; end
      end
      chk("R7 R13 writes until pin limit", 32'(n), 32'd61);
    end
    chk("R7 full at pin limit", 32'(full_n), 32'h0);
    mark_hold = 1'b0; tick();
    chk("R6 R7 leaving pin frees space", 32'(full_n), 32'h1);

    // R11 gap too short
    part_reset();
    for (int i = 0; i < 20; i++) put(16'h0400 + 16'(i));
    take(); take();
    mark_hold = 1'b1; tick();
    take();
    rewind_n = 1'b0; tick(); rewind_n = 1'b1;
    chk("R11 short gap flag kept", 32'(empty_n), 32'h1);
    take();
    chk("R11 short gap no rewind", 32'(rd_data), 32'h0403);
    mark_hold = 1'b0; tick();

    // Fall-through mode
    mrst_n = 1'b0; fall_strap = 1'b1; idle();
    tick(); tick();
    mrst_n = 1'b1; fall_strap = 1'b0;
    chk("R1 fall out_valid", 32'(out_valid), 32'h0);
    chk("R1 fall in_ready", 32'(in_ready), 32'h1);
    chk("R1 fall std flags", 32'({empty_n, full_n}), 32'h0);
    chk("R1 fall rd_data", 32'(rd_data), 32'h0);
    put(16'h0500);
    chk("R4 not yet valid", 32'(out_valid), 32'h0);
    tick();
    chk("R4 fell through", 32'({out_valid, rd_data}), 32'h10500);
    for (int i = 1; i < 70; i++) put(16'h0500 + 16'(i));
    chk("R4 holds without rd_en", 32'(rd_data), 32'h0500);
    for (int i = 0; i < 4; i++) take();
    chk("R4 advance on rd_en", 32'({out_valid, rd_data}), 32'h10504);
    mark_hold = 1'b1; tick();
    take(); take();
    chk("R6 fall pin then read", 32'(rd_data), 32'h0506);
    rewind_n = 1'b0; tick(); rewind_n = 1'b1;
    chk("R10 out_valid drops", 32'(out_valid), 32'h0);
    tick();
    chk("R10 pinned word reloaded", 32'({out_valid, rd_data}), 32'h10504);
    take();
    chk("R10 next needs rd_en", 32'(rd_data), 32'h0505);
    mark_hold = 1'b0; tick();
    part_reset();
    chk("R2 fall mode kept", 32'({in_ready, out_valid, full_n, empty_n}), 32'h8);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule